// File: doc/BRIEF.md
# Four-Cell Undervoltage Supervisor

This block watches a stack of four series battery cells. Each of the four per-cell differential voltages arrives as its own unsigned word, with a strobe marking the samples to use. On every strobed sample the block compares the cells against programmable limits. It then decides whether the pack is healthy, held in undervoltage, or tripped by an overvoltage cell or by an external control/thermal trip flag.

Two outputs act on that decision. The first is an enable for the downstream regulator, which is dropped while undervoltage is held. The second is a protection drive, which is raised on overvoltage or an external trip. A 2-bit mode code reports which case applies.

Undervoltage entry is time-filtered by a count of consecutive bad samples. Exit needs a hysteresis margin. A qualification floor lets packs with fewer than four cells short their unused inputs without causing false trips.

Top module: `cell_uv_guard`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to the healthy state: `reg_en`=1, `prot_drv`=0, `mode`=2'b00, and the bad-sample run count is cleared.
- R2: A cell whose reading is below `qual_lvl` is ignored both for undervoltage detection and for the exit test.
- R3: Undervoltage is entered on the strobed sample that completes N consecutive strobed samples with at least one qualified cell below `uv_lvl`. N is `uv_dly`, and a value of 0 acts as 1.
- R4: A strobed sample in which no qualified cell is below `uv_lvl` clears the run count, so a later undervoltage needs N fresh consecutive bad samples.
- R5: While undervoltage is held, `reg_en` is 0 and, absent a trip, `mode` is 2'b01.
- R6: Undervoltage is left only on a strobed sample in which every qualified cell is at or above `uv_lvl + uv_hys` (computed without overflow) and strictly below `ov_lvl`. Readings in the hysteresis band keep undervoltage held.
- R7: On every strobed sample, `prot_drv` becomes 1 if any cell (qualified or not) is above `ov_lvl` or `ctl_trip` is 1, and 0 otherwise. In that case `mode` is 2'b10 when a cell is above `ov_lvl`, and 2'b11 when only `ctl_trip` caused the trip.
- R8: The overvoltage and trip checks keep running during undervoltage. A sample with one cell above `ov_lvl` and another below `uv_lvl` while undervoltage is held gives `prot_drv`=1 and `reg_en`=0.
- R9: Outputs and internal state change only on clock edges where `smp_vld` is 1. Cell and trip inputs on other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe for cell words and trip flag |
| cell1_v | input | DW | Lowest cell differential |
| cell2_v | input | DW | Second cell differential |
| cell3_v | input | DW | Third cell differential |
| cell4_v | input | DW | Highest cell differential |
| ctl_trip | input | 1 | External control/thermal trip request |
| uv_lvl | input | DW | Undervoltage limit |
| uv_hys | input | DW | Exit hysteresis added to `uv_lvl` |
| ov_lvl | input | DW | Overvoltage limit |
| qual_lvl | input | DW | Floor below which a cell is treated as unused |
| uv_dly | input | CW | Consecutive bad samples needed to declare undervoltage |
| reg_en | output | 1 | Regulator enable |
| prot_drv | output | 1 | Protection drive |
| mode | output | 2 | 00 healthy, 01 undervoltage, 10 overvoltage, 11 external trip |

## Verification
The bench builds the block with DW=4 and CW=4, so every cell reading is one of only sixteen codes. With the limits placed at 2, 6, 8 (6+2) and 12, a random stream hits every region often: unused, low, hysteresis band, healthy, at the OV limit and above it. A stream restricted to codes 7 to 10 makes hysteresis stalls and clean exits frequent. The delay is stepped through 0 to 4 during the run, which exercises the zero-as-one rule and run lengths that cross the strobe gaps.

// File: rtl/cell_uv_guard.sv
module cell_uv_guard #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] cell1_v,
  input  logic [DW-1:0] cell2_v,
  input  logic [DW-1:0] cell3_v,
  input  logic [DW-1:0] cell4_v,
  input  logic          ctl_trip,
  input  logic [DW-1:0] uv_lvl,
  input  logic [DW-1:0] uv_hys,
  input  logic [DW-1:0] ov_lvl,
  input  logic [DW-1:0] qual_lvl,
  input  logic [CW-1:0] uv_dly,
  output logic          reg_en,
  output logic          prot_drv,
  output logic [1:0]    mode
);
  localparam int NC = 4;

  logic [DW-1:0] cv [NC];
  logic [NC-1:0] low, hi, ok;
  logic [DW:0]   rel_lvl;
  logic [CW-1:0] cnt, dly_eff;
  logic [CW:0]   cnt_nxt;
  logic          uv_q, out_q, ov_q;
  logic          any_low, any_ov, all_ok, hit;

  assign cv[0] = cell1_v;
  assign cv[1] = cell2_v;
  assign cv[2] = cell3_v;
  assign cv[3] = cell4_v;

  assign rel_lvl = {1'b0, uv_lvl} + {1'b0, uv_hys};

  for (genvar i = 0; i < NC; i++) begin : g_cell
    logic used;
    assign used  = cv[i] >= qual_lvl;
    assign low[i] = used && (cv[i] < uv_lvl);
    assign hi[i]  = cv[i] > ov_lvl;
    assign ok[i]  = !used || (({1'b0, cv[i]} >= rel_lvl) && (cv[i] < ov_lvl));
  end

  assign any_low = |low;
  assign any_ov  = |hi;
  assign all_ok  = &ok;

  assign dly_eff = (uv_dly == '0) ? CW'(1) : uv_dly;
  assign cnt_nxt = {1'b0, cnt} + 1'b1;
  assign hit     = cnt_nxt >= {1'b0, dly_eff};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uv_q  <= 1'b0;
      out_q <= 1'b0;
      ov_q  <= 1'b0;
      cnt   <= '0;
    end else if (smp_vld) begin
      out_q <= any_ov | ctl_trip;
      ov_q  <= any_ov;
      if (uv_q) begin
        cnt <= '0;
        if (all_ok) uv_q <= 1'b0;
      end else if (any_low) begin
        if (hit) begin
          uv_q <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt_nxt[CW-1:0];
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  assign reg_en   = !uv_q;
  assign prot_drv = out_q;
  assign mode     = out_q ? (ov_q ? 2'b10 : 2'b11) : (uv_q ? 2'b01 : 2'b00);
endmodule

module cell_uv_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_vld,
  input logic       ctl_trip,
  input logic       reg_en,
  input logic       prot_drv,
  input logic [1:0] mode
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (reg_en && !prot_drv && mode == 2'b00));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && $past(rst_n)) |=> ($stable(reg_en) && $stable(prot_drv) && $stable(mode)));

  // R5
  uv_reg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> !reg_en);

  // R7
  trip_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && ctl_trip) |=> prot_drv);

  // R7
  drive_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_drv |-> mode[1]);

  // R1
  healthy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (reg_en && !prot_drv));
endmodule

bind cell_uv_guard cell_uv_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .ctl_trip(ctl_trip),
  .reg_en(reg_en), .prot_drv(prot_drv), .mode(mode)
);

// File: tb/sim_cell_uv_guard.sv
module sim_cell_uv_guard;
  localparam int DW = 4;
  localparam int CW = 4;
  localparam int QL = 2, UL = 6, HY = 2, OL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic ctl_trip = 1'b0;
  logic [DW-1:0] c1 = '0, c2 = '0, c3 = '0, c4 = '0;
  logic [CW-1:0] dly = CW'(3);
  logic reg_en, prot_drv;
  logic [1:0] mode;

  int checks = 0, failures = 0;
  int m_uv = 0, m_run = 0, m_out = 0, m_ovf = 0;
  logic [31:0] lfsr = 32'h1ACE_B00F;

  always #10 clk = ~clk;

  cell_uv_guard #(.DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .cell1_v(c1), .cell2_v(c2), .cell3_v(c3), .cell4_v(c4),
    .ctl_trip(ctl_trip),
    .uv_lvl(DW'(UL)), .uv_hys(DW'(HY)), .ov_lvl(DW'(OL)), .qual_lvl(DW'(QL)),
    .uv_dly(dly),
    .reg_en(reg_en), .prot_drv(prot_drv), .mode(mode)
  );

  task automatic model_sample(input int v[4], input bit ctl);
    int lo = 0, ov = 0, good = 1, need;
    for (int i = 0; i < 4; i++) begin
      if (v[i] > OL) ov = 1;
      if (v[i] >= QL) begin
        if (v[i] < UL) lo = 1;
        if (!(v[i] >= UL + HY && v[i] < OL)) good = 0;
      end
    end
    m_out = (ov != 0 || ctl) ? 1 : 0;
    m_ovf = ov;
    need = (int'(dly) == 0) ? 1 : int'(dly);
    if (m_uv != 0) begin
      m_run = 0;
      if (good != 0) m_uv = 0;
    end else if (lo != 0) begin
      m_run++;
      if (m_run >= need) begin
        m_uv = 1;
        m_run = 0;
      end
    end else begin
      m_run = 0;
    end
  endtask

  task automatic compare(input string tag);
    logic er, ep;
    logic [1:0] em;
    er = (m_uv == 0);
    ep = (m_out != 0);
    em = ep ? ((m_ovf != 0) ? 2'b10 : 2'b11) : ((m_uv != 0) ? 2'b01 : 2'b00);
    checks++;
    if (reg_en !== er || prot_drv !== ep || mode !== em) begin
      failures++;
      $display("FAIL %s: reg_en/prot_drv/mode actual %b/%b/%b expected %b/%b/%b",
               tag, reg_en, prot_drv, mode, er, ep, em);
    end
  endtask

  task automatic step(input int a, input int b, input int c, input int d,
                      input bit ctl, input bit vld, input string tag);
    int v[4];
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    @(negedge clk);
    c1 = DW'(a); c2 = DW'(b); c3 = DW'(c); c4 = DW'(d);
    ctl_trip = ctl;
    smp_vld = vld;
    @(posedge clk);
    #1;
    if (vld) model_sample(v, ctl);
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_vld = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    m_uv = 0; m_run = 0; m_out = 0; m_ovf = 0;
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] adv(input logic [31:0] s);
    return s[0] ? ((s >> 1) ^ 32'hA300_0001) : (s >> 1);
  endfunction

  initial begin
    do_reset();
    // R4: runs broken by a clean sample never reach the delay of 3
    step(3, 9, 9, 9, 0, 1, "R4 run1");
    step(3, 9, 9, 9, 0, 1, "R4 run2");
    step(9, 9, 9, 9, 0, 1, "R4 clear");
    step(9, 3, 9, 9, 0, 1, "R4 restart1");
    step(9, 3, 9, 9, 0, 1, "R4 restart2");
    // R3, R5: third consecutive low sample enters undervoltage
    step(9, 9, 3, 9, 0, 1, "R3 enter");
    if (reg_en !== 1'b0 || mode !== 2'b01) begin
      failures++;
      $display("FAIL R5: reg_en/mode actual %b/%b expected 0/01", reg_en, mode);
    end
    checks++;
    // R9: strobe low with healthy cells changes nothing
    step(9, 9, 9, 9, 1, 0, "R9 idle");
    // R6: hysteresis band and OV-limit reading keep undervoltage
    step(7, 9, 9, 9, 0, 1, "R6 band");
    step(8, 9, 9, 12, 0, 1, "R6 at ov");
    step(8, 9, 9, 11, 0, 1, "R6 exit");
    // R2: unqualified cell never trips
    for (int k = 0; k < 5; k++) step(1, 9, 9, 9, 0, 1, "R2 unused");
    step(9, 9, 9, 3, 0, 1, "R2 low1");
    step(9, 9, 9, 3, 0, 1, "R2 low2");
    step(9, 9, 9, 3, 0, 1, "R2 low3");
    step(1, 8, 8, 8, 0, 1, "R2 exit ignores unused");
    // R8: imbalanced pack while in undervoltage
    step(3, 9, 9, 9, 0, 1, "R8 a");
    step(3, 9, 9, 9, 0, 1, "R8 b");
    step(3, 9, 9, 9, 0, 1, "R8 c");
    step(3, 13, 9, 9, 0, 1, "R8 ov+uv");
    if (prot_drv !== 1'b1 || reg_en !== 1'b0) begin
      failures++;
      $display("FAIL R8: prot_drv/reg_en actual %b/%b expected 1/0", prot_drv, reg_en);
    end
    checks++;
    // R7: trip only, trip with OV, clear
    step(9, 9, 9, 9, 1, 1, "R7 ctl");
    step(9, 9, 15, 9, 1, 1, "R7 ov+ctl");
    step(0, 9, 9, 13, 0, 1, "R7 ov unused");
    step(9, 9, 9, 9, 0, 1, "R7 clear");
    // R3: zero delay behaves as one
    dly = '0;
    step(9, 9, 9, 9, 0, 1, "R3 d0 pre");
    step(9, 5, 9, 9, 0, 1, "R3 d0 enter");
    do_reset();
    // Sweep: random and band-restricted streams with stepped delay
    for (int k = 0; k < 6000; k++) begin
      int v[4];
      bit ctl, vld;
      lfsr = adv(lfsr);
      dly = CW'((k / 500) % 5);
      for (int i = 0; i < 4; i++)
        v[i] = ((k / 200) % 2 == 1) ? 7 + int'(lfsr[2*i +: 2]) : int'(lfsr[4*i +: 4]);
      ctl = (lfsr[19:16] == 4'h0);
      vld = (lfsr[21:20] != 2'b00);
      step(v[0], v[1], v[2], v[3], ctl, vld, vld ? "R7 R6 R3 sweep" : "R9 sweep idle");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: run actual hung expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule